// File: doc/BRIEF.md
# SD command issue and response engine

This block launches one SD card command at a time on the single command line and collects the card's reply. Software loads a 32-bit argument, then writes a 16-bit command word with its launch flag set. The engine builds a 48-bit command frame from the argument and the command index, and appends a CRC7 with polynomial x^7+x^3+1. It shifts the frame out MSB first, one bit for each pulse of a bit-rate clock enable.

Depending on the command word, the engine then returns to idle, or it receives a 48-bit or a 136-bit reply. A short reply has its CRC7 checked. The engine may then wait for the card to release DAT0 after a busy period. A countdown register bounds both the wait for the reply's start bit and the busy wait. Completion is seen as the launch flag clearing in the command register. Errors set a fail flag there and cause bits in a write-one-to-clear status register. The reply is read from four response words.

Top module: `sdc_cmd_engine`

Register map, by word address (`wr_addr`/`rd_addr`): 0 command, 1 argument, 2 timeout start value, 3 status, 4 to 7 response words 0 to 3.

## Requirements
- R1: After reset the command word, argument, status and response words read 0, the timeout register reads its reset parameter (256 by default), and `cmd_oe` is low. A write to the argument register reads back unchanged.
- R2: A launch drives `cmd_oe` high for exactly 48 bit periods. Each bit holds from one `bit_tick` to the next. The frame is, MSB first: start 0, transmission bit 1, command index (command bits 5:0), argument, CRC7 over those 40 bits, end bit 1. `cmd_out` is high whenever `cmd_oe` is low.
- R3: Command bit 15 (launch) stays set until the command finishes and then clears by itself. A command with bit 10 (no reply) set finishes when its frame ends, with bit 14 (fail) clear.
- R4: A write to the command register while bit 15 is set has no effect. The index, the flags and the frame in flight are kept.
- R5: A short reply is 48 bits, starting with the first 0 seen on `cmd_in` at a tick. Its bits 39:8 go to response word 0. If the CRC7 computed over bits 47:8 differs from bits 7:1, the engine sets status bit 4 and the fail flag.
- R6: With command bit 9 (long reply) set, the engine takes 136 bits with no CRC check. The last 128 bits go to the response words, word 0 holding bits 31:0 and word 3 holding bits 127:96.
- R7: The countdown loads the timeout value T at the end of the frame. A start bit seen on the T-th tick after that is still accepted. If no start bit has arrived by then, the engine sets status bit 6 and the fail flag.
- R8: With command bit 11 (busy wait) set and a good reply, the launch flag stays set until `dat0_in` is high at a tick. The engine then sets status bit 10 and finishes without fail.
- R9: If `dat0_in` stays low for T ticks of the busy wait, the engine sets status bit 7 and the fail flag.
- R10: A launch with both bit 9 and bit 11 set is refused. No frame is sent, bit 15 stays clear, bit 14 is set, and the status is unchanged.
- R11: A 1 written to a status bit clears it and a 0 leaves it. A new launch clears the fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable at the command line bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| cmd_out | output | 1 | Command line value driven toward the card |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line value from the card |
| dat0_in | input | 1 | DAT0 level, low while the card is busy |

## Verification
The bench probes the timeout edge from both sides. A start bit on the last allowed tick must be accepted, and silence must time out: an off-by-one counter fails one of the two. It corrupts a reply CRC by one bit, which exposes a checker that looks at the wrong field. It also writes a second command while one is in flight, which exposes a design that restarts or re-indexes. It holds DAT0 low past the reply, which exposes an engine that finishes before the card releases busy. It checks that a refused long-plus-busy request produces no frame, where a careless design would still send the frame on the line.

// File: rtl/sdc_pkg.sv
// Shared constants, state type and CRC7 function of the SD command engine.
// Assumes a fixed 8-word register window of 32-bit registers.
package sdc_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int FRAME_W   = 48;
    localparam int LONG_W    = 136;
    localparam int CRC_W     = 7;
    localparam int IDX_W     = 6;
    localparam int STS_W     = 11;
    localparam int KEEP_W    = 14;
    localparam int RSP_WORDS = 4;
    localparam int MSG_W     = FRAME_W - CRC_W - 1;

    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ARG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOUT = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS  = 3'd3;

    // command word bit positions
    localparam int CB_NEW   = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSY  = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;

    // status bit positions
    localparam int SB_BUSYDONE = 10;
    localparam int SB_RWTO     = 7;
    localparam int SB_CMDTO    = 6;
    localparam int SB_CRC7     = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY
    } eng_state_t;

    // Serial CRC7 (x^7+x^3+1) over a message, MSB first.
    function automatic logic [CRC_W-1:0] crc7_calc(input logic [MSG_W-1:0] msg);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ msg[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction
endpackage

// File: rtl/sdc_frame_tx.sv
// Command frame serializer: loads a frame and shifts it out MSB first,
// one bit per bit_tick. Assumes no load while a frame is in flight.
module sdc_frame_tx #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               line_out,
    output logic               line_oe,
    output logic               done
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;

    // Shift register and count of bits still to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= frame;
            left_q <= CNT_W'(FRAME_W);
        end else if (left_q != '0 && bit_tick) begin
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b1};
            left_q <= left_q - 1'b1;
        end
    end

    assign line_oe  = (left_q != '0);
    assign line_out = line_oe ? sh_q[FRAME_W-1] : 1'b1;
    assign done     = bit_tick && (left_q == CNT_W'(1));
endmodule

// File: rtl/sdc_resp_rx.sv
// Reply receiver: while armed, waits for a 0 on the line at a tick, then
// gathers a short or long reply. The reply ends right-aligned in `bits`, and
// `done` pulses one cycle after the last bit. Assumes long_sel is stable.
module sdc_resp_rx #(
    parameter int SHORT_W = 48,
    parameter int LONG_W  = 136
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              arm,
    input  logic              long_sel,
    input  logic              line_in,
    output logic              started,
    output logic              done,
    output logic [LONG_W-1:0] bits
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    logic             active_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;

    assign target  = long_sel ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
    assign started = arm && !active_q && bit_tick && !line_in;
    assign done    = done_q;

    // Capture of the start bit and the following reply bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
            bits     <= '0;
        end else begin
            done_q <= 1'b0;
            if (started) begin
                active_q <= 1'b1;
                cnt_q    <= CNT_W'(1);
                bits     <= '0;
            end else if (active_q && bit_tick) begin
                bits  <= {bits[LONG_W-2:0], line_in};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == target - 1'b1) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdc_timer.sv
// Countdown for reply and busy waits: loads a start value, steps down on
// request, and flags the step that exhausts it (start value 0 or 1 expires
// on the first step).
module sdc_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] start_val,
    input  logic         step,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q <= W'(1));

    // Remaining step count.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= start_val;
        else if (step && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/sdc_cmd_engine.sv
// SD command issue and response engine. Holds the register window, builds
// the command frame with its CRC7, sequences send, reply wait, reply capture
// and busy wait, and records completion and error causes.
// Assumes bit_tick is a single-cycle pulse and software waits for the
// launch flag to clear before launching again.
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter logic [REG_W-1:0] TOUT_RESET = 32'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in,
    input  logic              dat0_in
);
    eng_state_t                       state_q, state_d;
    logic [REG_W-1:0]                 arg_q, tout_q;
    logic [KEEP_W-1:0]                cmd_q;
    logic                             new_q, fail_q;
    logic [STS_W-1:0]                 sts_q, sts_set, sts_clr;
    logic [RSP_WORDS-1:0][REG_W-1:0]  rsp_q;

    logic             cmd_wr, launch, reject, combo;
    logic [MSG_W-1:0] msg;
    logic [FRAME_W-1:0] frame;
    logic             tx_done, rx_start, rx_done, crc_ok;
    logic [LONG_W-1:0] rx_bits;
    logic [FRAME_W-1:0] short_frame;
    logic             fin, fin_err, tmr_load, tmr_step, tmr_last;
    logic             short_store, long_store;

    // Decode of command writes, launch and refusal.
    assign cmd_wr = wr_en && (wr_addr == A_CMD) && !new_q;
    assign combo  = wr_data[CB_LONG] && wr_data[CB_BUSY];
    assign launch = cmd_wr && wr_data[CB_NEW] && !combo;
    assign reject = cmd_wr && wr_data[CB_NEW] && combo;

    assign msg   = {1'b0, 1'b1, wr_data[IDX_W-1:0], arg_q};
    assign frame = {msg, crc7_calc(msg), 1'b1};

    sdc_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(launch),
        .frame(frame), .line_out(cmd_out), .line_oe(cmd_oe), .done(tx_done)
    );

    sdc_resp_rx #(.SHORT_W(FRAME_W), .LONG_W(LONG_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .arm(state_q == ST_WAIT), .long_sel(cmd_q[CB_LONG]), .line_in(cmd_in),
        .started(rx_start), .done(rx_done), .bits(rx_bits)
    );

    sdc_timer #(.W(REG_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .start_val(tout_q),
        .step(tmr_step), .last(tmr_last)
    );

    assign short_frame = rx_bits[FRAME_W-1:0];
    assign crc_ok = (crc7_calc(short_frame[FRAME_W-1:CRC_W+1]) == short_frame[CRC_W:1]);

    // Sequencer: next state, completion and status causes.
    always_comb begin
        state_d     = state_q;
        fin         = 1'b0;
        fin_err     = 1'b0;
        sts_set     = '0;
        tmr_load    = 1'b0;
        tmr_step    = 1'b0;
        short_store = 1'b0;
        long_store  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_SEND;
            ST_SEND: if (tx_done) begin
                if (cmd_q[CB_NORSP]) begin
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                end else begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rx_start) begin
                    state_d = ST_RECV;
                end else if (bit_tick) begin
                    tmr_step = 1'b1;
                    if (tmr_last) begin
                        state_d            = ST_IDLE;
                        fin                = 1'b1;
                        fin_err            = 1'b1;
                        sts_set[SB_CMDTO]  = 1'b1;
                    end
                end
            end
            ST_RECV: if (rx_done) begin
                if (cmd_q[CB_LONG]) begin
                    long_store = 1'b1;
                    state_d    = ST_IDLE;
                    fin        = 1'b1;
                end else begin
                    short_store = 1'b1;
                    if (!crc_ok) begin
                        state_d          = ST_IDLE;
                        fin              = 1'b1;
                        fin_err          = 1'b1;
                        sts_set[SB_CRC7] = 1'b1;
                    end else if (cmd_q[CB_BUSY]) begin
                        state_d  = ST_BUSY;
                        tmr_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
            ST_BUSY: if (bit_tick) begin
                if (dat0_in) begin
                    state_d              = ST_IDLE;
                    fin                  = 1'b1;
                    sts_set[SB_BUSYDONE] = 1'b1;
                end else begin
                    tmr_step = 1'b1;
                    if (tmr_last) begin
                        state_d          = ST_IDLE;
                        fin              = 1'b1;
                        fin_err          = 1'b1;
                        sts_set[SB_RWTO] = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sts_clr = (wr_en && wr_addr == A_STS) ? wr_data[STS_W-1:0] : '0;

    // State, command word flags and status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            new_q   <= 1'b0;
            fail_q  <= 1'b0;
            sts_q   <= '0;
        end else begin
            state_q <= state_d;
            sts_q   <= (sts_q & ~sts_clr) | sts_set;
            if (cmd_wr) cmd_q <= wr_data[KEEP_W-1:0];
            if (launch) begin
                new_q  <= 1'b1;
                fail_q <= 1'b0;
            end else if (reject) begin
                fail_q <= 1'b1;
            end else if (fin) begin
                new_q  <= 1'b0;
                fail_q <= fin_err;
            end
        end
    end

    // Argument and timeout registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            tout_q <= TOUT_RESET;
        end else if (wr_en) begin
            if (wr_addr == A_ARG)  arg_q  <= wr_data;
            if (wr_addr == A_TOUT) tout_q <= wr_data;
        end
    end

    // Response words: long replies fill all, short replies only word 0.
    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_rsp
        if (w == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n)          rsp_q[w] <= '0;
                else if (long_store) rsp_q[w] <= rx_bits[w*REG_W +: REG_W];
                else if (short_store) rsp_q[w] <= short_frame[CRC_W+1 +: REG_W];
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n)          rsp_q[w] <= '0;
                else if (long_store) rsp_q[w] <= rx_bits[w*REG_W +: REG_W];
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CMD:   rd_data = {16'h0, new_q, fail_q, cmd_q};
            A_ARG:   rd_data = arg_q;
            A_TOUT:  rd_data = tout_q;
            A_STS:   rd_data = {{(REG_W-STS_W){1'b0}}, sts_q};
            default: rd_data = rsp_q[rd_addr[1:0]];
        endcase
    end
endmodule

// File: rtl/sdc_engine_chk.sv
// Assertion checker for the SD command engine, bound to every instance.
module sdc_engine_chk
    import sdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              cmd_out,
    input logic              cmd_oe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              new_q,
    input logic              fail_q,
    input logic [IDX_W-1:0]  cmd_idx,
    input logic [STS_W-1:0]  sts_q
);
    // R2
    oe_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> new_q);
    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && !bit_tick) |=> $stable(cmd_out));
    // R3
    done_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(new_q) |-> !cmd_oe);
    // R4
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMD && new_q) |=> (cmd_idx == $past(cmd_idx)));
    // R10
    combo_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CMD && !new_q && wr_data[CB_NEW]
         && wr_data[CB_LONG] && wr_data[CB_BUSY]) |=> (!new_q && fail_q && !cmd_oe));
    // R7
    timeout_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[SB_CMDTO]) |-> fail_q);
endmodule

bind sdc_cmd_engine sdc_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .new_q(new_q), .fail_q(fail_q), .cmd_idx(cmd_q[5:0]), .sts_q(sts_q)
);

// File: tb/sim_sdc_cmd_engine.sv
module sim_sdc_cmd_engine;
    localparam int CLK_NS = 10;
    localparam logic [15:0] F_NEW = 16'h8000, F_LONG = 16'h0200,
                            F_NORSP = 16'h0400, F_BUSY = 16'h0800;

    logic        clk = 1'b0, rst_n = 1'b0, bit_tick;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        cmd_out, cmd_oe, cmd_in = 1'b1, dat0_in = 1'b1;
    logic [1:0]  tdiv = '0;

    int n_checks = 0, n_fail = 0, frames_seen = 0, mon_n = 0;
    logic [47:0] exp_q[$];
    logic [47:0] mon_sh = '0;
    bit finished = 0;

    sdc_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in)
    );

    always #(CLK_NS/2) clk = ~clk;
    assign bit_tick = (tdiv == 2'd3);
    initial forever begin @(posedge clk); tdiv <= tdiv + 1'b1; end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // CRC7 by long division of message*x^7 by 0x89.
    function automatic logic [6:0] tb_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    function automatic logic [47:0] mk_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, tb_crc({2'b01, idx, arg}), 1'b1};
    endfunction

    // Monitor: rebuilds frames from the line and compares with the scoreboard.
    initial forever begin
        @(negedge clk);
        if (rst_n && cmd_oe && bit_tick) begin
            mon_sh = {mon_sh[46:0], cmd_out};
            mon_n++;
            if (mon_n == 48) begin
                mon_n = 0;
                frames_seen++;
                if (exp_q.size() == 0) check(0, "R2 unexpected frame", mon_sh, 0);
                else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    check(mon_sh == e, "R2 frame content", mon_sh, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); rd_addr = a; #1; d = rd_data;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!bit_tick);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [15:0] flags, input logic [31:0] arg);
        reg_write(3'd1, arg);
        exp_q.push_back(mk_frame(idx, arg));
        reg_write(3'd0, {16'h0, F_NEW | flags | {10'h0, idx}});
    endtask

    task automatic wait_frame_end();
        while (!cmd_oe) @(negedge clk);
        while (cmd_oe) @(negedge clk);
    endtask

    task automatic card_send(input logic [135:0] v, input int len, input int dly);
        repeat (dly) wait_tick();
        for (int i = len - 1; i >= 0; i--) begin wait_tick(); cmd_in = v[i]; end
        wait_tick(); cmd_in = 1'b1;
    endtask

    task automatic card_short(input logic [5:0] idx, input logic [31:0] pl, input bit bad, input int dly);
        logic [39:0] m;
        m = {2'b00, idx, pl};
        card_send({88'h0, m, tb_crc(m) ^ {6'h0, bad}, 1'b1}, 48, dly);
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            reg_read(3'd0, v);
            if (!v[15]) return;
        end
        check(0, "R3 launch flag never cleared", v, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [127:0] lp;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd0, v); check(v == 0, "R1 command reset", v, 0);
        reg_read(3'd3, v); check(v == 0, "R1 status reset", v, 0);
        reg_read(3'd2, v); check(v == 32'd256, "R1 timeout reset", v, 256);
        reg_read(3'd4, v); check(v == 0, "R1 response reset", v, 0);
        check(cmd_oe == 1'b0, "R1 line idle", cmd_oe, 0);
        check(mk_frame(6'd0, 32'd0) == 48'h400000000095, "R2 reference frame", mk_frame(0, 0), 48'h400000000095);

        // R3 no-reply command
        issue(6'd0, F_NORSP, 32'h0);
        wait_done();
        reg_read(3'd0, v); check(v[15:14] == 2'b00, "R3 no-reply finish", v, 0);
        reg_read(3'd1, v); check(v == 32'h0, "R1 argument readback", v, 0);
        check(frames_seen == 1, "R2 one frame", frames_seen, 1);

        // R5 good short reply
        issue(6'd17, 16'h0, 32'h0000_0200);
        wait_frame_end(); card_short(6'd17, 32'hA5C3_0F96, 0, 2);
        wait_done();
        reg_read(3'd4, v); check(v == 32'hA5C3_0F96, "R5 short payload", v, 32'hA5C30F96);
        reg_read(3'd3, v); check(v == 0, "R5 no error", v, 0);
        reg_read(3'd0, v); check(v[14] == 1'b0, "R5 fail clear", v, 0);

        // R5 bad CRC
        issue(6'd13, 16'h0, 32'h1234_5678);
        wait_frame_end(); card_short(6'd13, 32'h0BAD_F00D, 1, 1);
        wait_done();
        reg_read(3'd3, v); check(v == 32'h10, "R5 crc error bit", v, 32'h10);
        reg_read(3'd0, v); check(v[14] == 1'b1, "R5 crc fail flag", v[14], 1);
        reg_read(3'd4, v); check(v == 32'h0BAD_F00D, "R5 payload kept", v, 32'h0BADF00D);

        // R7 timeout with silent card
        reg_write(3'd2, 32'd4);
        issue(6'd8, 16'h0, 32'h0000_01AA);
        wait_frame_end();
        wait_done();
        reg_read(3'd3, v); check(v == 32'h50, "R7 timeout bit", v, 32'h50);
        reg_read(3'd0, v); check(v[14] == 1'b1, "R7 fail flag", v[14], 1);

        // R11 write-one-to-clear
        reg_write(3'd3, 32'h40);
        reg_read(3'd3, v); check(v == 32'h10, "R11 selective clear", v, 32'h10);
        reg_write(3'd3, 32'h7FF);
        reg_read(3'd3, v); check(v == 0, "R11 full clear", v, 0);

        // R7 start bit on the last allowed tick
        issue(6'd9, 16'h0, 32'hCAFE_0001);
        reg_read(3'd0, v); check(v[14] == 1'b0, "R11 launch clears fail", v[14], 0);
        wait_frame_end(); card_short(6'd9, 32'h0000_0900, 0, 3);
        wait_done();
        reg_read(3'd3, v); check(v == 0, "R7 boundary accepted", v, 0);
        reg_read(3'd4, v); check(v == 32'h0000_0900, "R7 boundary payload", v, 32'h900);

        // R6 long reply
        reg_write(3'd2, 32'd20);
        lp = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
        issue(6'd2, F_LONG, 32'h0);
        wait_frame_end(); card_send({2'b00, 6'h3F, lp}, 136, 1);
        wait_done();
        for (int w = 0; w < 4; w++) begin
            reg_read(3'(4 + w), v);
            check(v == lp[w*32 +: 32], "R6 long word", v, lp[w*32 +: 32]);
        end

        // R8 busy wait
        issue(6'd7, F_BUSY, 32'h0000_0007);
        wait_frame_end();
        dat0_in = 1'b0;
        card_short(6'd7, 32'h0000_0800, 0, 1);
        repeat (6) wait_tick();
        reg_read(3'd0, v); check(v[15] == 1'b1, "R8 held while busy", v[15], 1);
        dat0_in = 1'b1;
        wait_done();
        reg_read(3'd3, v); check(v == 32'h400, "R8 busy done bit", v, 32'h400);
        reg_read(3'd0, v); check(v[14] == 1'b0, "R8 no fail", v[14], 0);
        reg_write(3'd3, 32'h7FF);

        // R9 busy timeout
        reg_write(3'd2, 32'd3);
        issue(6'd7, F_BUSY, 32'h0000_0008);
        wait_frame_end();
        dat0_in = 1'b0;
        card_short(6'd7, 32'h0000_0800, 0, 0);
        wait_done();
        reg_read(3'd3, v); check(v == 32'h80, "R9 busy timeout bit", v, 32'h80);
        reg_read(3'd0, v); check(v[14] == 1'b1, "R9 fail flag", v[14], 1);
        dat0_in = 1'b1;
        reg_write(3'd3, 32'h7FF);

        // R10 refused long plus busy
        n = frames_seen;
        reg_write(3'd0, {16'h0, F_NEW | F_LONG | F_BUSY | 16'd5});
        repeat (300) @(negedge clk);
        reg_read(3'd0, v); check(v[15:14] == 2'b01, "R10 refused flags", v[15:14], 2'b01);
        reg_read(3'd3, v); check(v == 0, "R10 status unchanged", v, 0);
        check(frames_seen == n, "R10 no frame", frames_seen, n);

        // R4 write while a command is in flight
        reg_write(3'd2, 32'd40);
        n = frames_seen;
        issue(6'd13, 16'h0, 32'h0000_ABCD);
        wait_frame_end();
        reg_write(3'd0, {16'h0, F_NEW | F_NORSP | 16'd2});
        reg_read(3'd0, v); check(v[15] == 1'b1 && v[5:0] == 6'd13, "R4 index kept", v, 32'h800D);
        card_short(6'd13, 32'h0000_0D0D, 0, 1);
        wait_done();
        repeat (400) @(negedge clk);
        check(frames_seen == n + 1, "R4 single frame", frames_seen, n + 1);
        reg_read(3'd4, v); check(v == 32'h0000_0D0D, "R4 reply of first command", v, 32'hD0D);
        check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule